// File: doc/BRIEF.md
# Round-Robin DMA Channel Arbiter

This block decides which of six DMA channels may use the transfer engine. Each channel raises a request line. When the arbiter is idle it samples those lines and grants exactly one channel. The winner is the channel that stands highest in a rotating priority order. The grant stays in place until the transfer engine pulses a completion strobe, and no later request can take it away.

When a transfer finishes, the whole order shifts cyclically. The channel that just finished becomes the lowest and the channel after it becomes the highest. The shift also moves channels that had nothing pending, so over time every channel gets a fair turn.

The order is kept as a single head index, which names the highest-priority channel. The head index is also driven out so that the rest of the system can see it. Requests are not latched: a channel that lowers its line before it is served loses its turn.

Top module: `rr_dma_arbiter`

## Requirements
- R1: A synchronous active-high `rst` clears the grant and `busy` and sets `head_idx` to 0. The order is then 0 > 1 > 2 > 3 > 4 > 5. This also applies when `rst` arrives during a transfer.
- R2: `grant` is one-hot or zero. When `busy` is 1, bit `grant_idx` of `grant` is the only bit set. When `busy` is 0, `grant` is zero.
- R3: If the arbiter is idle and sees at least one request at a clock edge, `busy` and `grant` rise at that edge. The grant goes to the first requesting channel found by walking from `head_idx` upward modulo 6.
- R4: While `busy` is 1 and `done` is 0, `grant` stays unchanged whatever `req` does.
- R5: When `done` is 1 while `busy` is 1, the grant drops at that edge and `head_idx` becomes (`grant_idx` + 1) mod 6. For example, channel 5 finishing gives head 0.
- R6: The rotation passes over channels with no pending request. Under head 2, a finish on channel 3 gives head 4.
- R7: After a rotation, the next grant uses the new order. This can wrap, so under head 4 with requests only on channels 0 and 1, channel 0 wins.
- R8: A `done` pulse while `busy` is 0 changes neither `head_idx` nor the grant.
- R9: A request withdrawn before it is granted is forgotten and never produces a grant.
- R10: With no request, an idle arbiter stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of grant and priority order |
| req | input | 6 | Per-channel transfer request |
| done | input | 1 | Completion strobe for the granted transfer |
| grant | output | 6 | One-hot grant, zero when idle |
| grant_idx | output | 3 | Index of the granted channel |
| busy | output | 1 | A grant is active |
| head_idx | output | 3 | Channel that currently has the highest priority |

## Verification
A grant is due one clock edge after an idle arbiter sees a request, so it is first visible at the falling edge that follows that rising edge. The completion strobe clears `busy` and updates `head_idx` at the same edge that samples it. A channel still requesting at that point is granted one edge later. The bench drives inputs on falling edges. It pushes the expected channel index into a queue before each grant is due, and a falling-edge monitor pops the queue and compares whenever `busy` rises. The head index and the idle state are checked at the falling edge directly after each completion pulse.

// File: rtl/rr_dma_arbiter.sv
module rr_dma_arbiter #(
  parameter int NCH = 6,
  parameter int IW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] req,
  input  logic           done,
  output logic [NCH-1:0] grant,
  output logic [IW-1:0]  grant_idx,
  output logic           busy,
  output logic [IW-1:0]  head_idx
);

  logic          busy_q;
  logic [IW-1:0] gidx_q, head_q, pick;
  logic          found;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] i);
    return (i == IW'(NCH - 1)) ? '0 : i + 1'b1;
  endfunction

  always_comb begin
    logic [IW-1:0] c;
    c     = head_q;
    pick  = '0;
    found = 1'b0;
    for (int k = 0; k < NCH; k++) begin
      if (!found && req[c]) begin
        found = 1'b1;
        pick  = c;
      end
      c = step(c);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      gidx_q <= '0;
      head_q <= '0;
    end else if (busy_q) begin
      if (done) begin
        busy_q <= 1'b0;
        head_q <= step(gidx_q);
      end
    end else if (found) begin
      busy_q <= 1'b1;
      gidx_q <= pick;
    end
  end

  assign grant     = busy_q ? (NCH'(1) << gidx_q) : '0;
  assign grant_idx = gidx_q;
  assign busy      = busy_q;
  assign head_idx  = head_q;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!busy && grant == '0 && head_idx == '0));

  a_r2_onehot_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && (busy == (grant != '0)));

  a_r3_grant_was_requested: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (|($past(req) & grant)));

  a_r4_hold_grant: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> (busy && $stable(grant)));

  a_r5_rotate_on_done: assert property (@(posedge clk) disable iff (rst)
    (busy && done) |=> (!busy && head_idx == step($past(grant_idx))));

  a_r8_idle_done_ignored: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(head_idx));

  a_r10_stay_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && req == '0) |=> !busy);

endmodule

// File: tb/rr_dma_arbiter_test.sv
module rr_dma_arbiter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] req = '0;
  logic       done = 1'b0;
  logic [5:0] grant;
  logic [2:0] grant_idx;
  logic       busy;
  logic [2:0] head_idx;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  bit prev_busy = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rr_dma_arbiter uut (
    .clk(clk), .rst(rst), .req(req), .done(done),
    .grant(grant), .grant_idx(grant_idx), .busy(busy), .head_idx(head_idx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_grant(input int ch);
    exp_q.push_back(ch);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_xfer(input int exp_head, input string tag);
    @(negedge clk) done = 1'b1;
    @(negedge clk) done = 1'b0;
    chk(busy == 1'b0, {tag, " busy drops on done"}, busy, 0);
    chk(head_idx == exp_head, {tag, " head after rotation"}, head_idx, exp_head);
  endtask

  always @(negedge clk) begin
    if (!rst && busy && !prev_busy) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected grant", grant_idx, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(grant_idx == e, "R3 granted channel", grant_idx, e);
        chk(grant == (6'd1 << e), "R2 one-hot grant", grant, 1 << e);
      end
    end
    prev_busy = busy;
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rst = 1'b0;
    chk(busy == 0 && grant == 0, "R1 idle after reset", grant, 0);
    chk(head_idx == 0, "R1 head after reset", head_idx, 0);

    cycles(3);
    chk(busy == 0, "R10 no request stays idle", busy, 0);

    expect_grant(0);
    req = 6'b001001;
    cycles(2);
    req = 6'b001010;
    cycles(3);
    chk(grant == 6'b000001, "R4 no preemption while busy", grant, 1);
    expect_grant(1);
    finish_xfer(1, "R5");
    cycles(2);
    expect_grant(3);
    finish_xfer(2, "R5");
    cycles(2);
    req = 6'b001000;
    finish_xfer(4, "R6");
    req = '0;
    cycles(2);
    chk(busy == 0, "R10 idle after last transfer", busy, 0);

    @(negedge clk) done = 1'b1;
    @(negedge clk) done = 1'b0;
    cycles(1);
    chk(head_idx == 4, "R8 idle done ignored", head_idx, 4);
    chk(busy == 0, "R8 idle done no grant", busy, 0);

    expect_grant(0);
    req = 6'b000011;
    cycles(2);
    chk(grant_idx == 0, "R7 wrap under head 4", grant_idx, 0);
    req = 6'b100010;
    cycles(2);
    req = 6'b000010;
    expect_grant(1);
    finish_xfer(1, "R7");
    cycles(2);
    req = '0;
    finish_xfer(2, "R5");
    cycles(4);
    chk(busy == 0, "R9 withdrawn request dropped", busy, 0);

    expect_grant(5);
    req = 6'b100000;
    cycles(2);
    req = '0;
    finish_xfer(0, "R5 wrap");

    expect_grant(2);
    req = 6'b000100;
    cycles(2);
    req = '0;
    finish_xfer(3, "R5");
    expect_grant(4);
    req = 6'b010000;
    cycles(2);
    req = '0;
    rst = 1'b1;
    cycles(1);
    rst = 1'b0;
    chk(busy == 0 && grant == 0, "R1 reset mid transfer", grant, 0);
    chk(head_idx == 0, "R1 head after mid reset", head_idx, 0);

    cycles(2);
    chk(exp_q.size() == 0, "R3 all expected grants seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule